// File: doc/BRIEF.md
# Dual-Edge Pulse Width Capture Channel

This timer channel measures the width of pulses on a single input pin. It takes a snapshot of one of two free-running 16-bit time base buses on each of two edges of opposite polarity. The leading edge of a pulse goes into a hidden staging register. The trailing edge goes into data register A. On that same trailing edge the staged value moves into the readable register B, so A and B always describe the same pulse. Software reads the pair and subtracts B from A to get the width. A sticky flag, brought out as the interrupt line, marks that a complete pair is ready.

A 4-bit mode field chooses the behaviour. Code 0 is the disable state, and every code other than 1 acts the same way. In that state nothing is captured and the flag is held low. The synchronised pin level can still be read, and software may preload register B. Code 1 runs pulse-width measurement. A polarity bit sets whether the leading edge is rising or falling. A select bit sets which time base is sampled. Any write that changes the mode re-arms the sequencer, so the next capture must again be a leading edge.

Top module: `pwcap_channel`

## Requirements
- R1: For any mode code other than 1 (0 included), nothing is captured into A or B and the flag reads 0. Entering such a mode clears a set flag on the same edge. Control register (address 0) bit 9 shows the pin level after a two-flop synchroniser.
- R2: When the mode is not 1, a write to address 2 loads the value into both the staging register and B, and a later read of address 2 returns it. In mode 1, writes to address 2 are ignored.
- R3: In mode 1, a pin change between clock edges k-1 and k is sampled on edge k+2. A trailing-edge capture stores the selected time base value present just before that edge into A (read at address 1).
- R4: Control bit 4 sets the polarity. With 0, the leading edge is rising and the trailing edge is falling. With 1, the leading edge is falling and the trailing edge is rising.
- R5: A trailing edge that arrives while no leading edge has been staged is ignored: A, B and the flag are unchanged.
- R6: A leading-edge capture stores the time base in the staging register only. The flag and the value read at address 2 do not change.
- R7: A trailing-edge capture writes A, copies the staging register into B and sets the flag (control bit 8), all on one clock edge.
- R8: Further complete pulses while the flag is set overwrite A and B with the newest values, and the flag stays set.
- R9: Control bit 5 selects the time base: 0 samples tb_a, 1 samples tb_b.
- R10: Writing control with bit 8 set clears the flag. If that write lands on the same edge as a trailing-edge capture, the flag ends set.
- R11: A control write that changes bits 3:0 re-arms the sequencer, and a trailing edge that follows it is ignored. A capture is suppressed on the edge of that write.
- R12: rd_data is registered. It shows the register addressed by rd_addr one clock after rd_addr is applied. The map is: 0 = control {bit9 pin, bit8 flag, bit5 select, bit4 polarity, bits3:0 mode}, 1 = A, 2 = B, 3 = zero. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| tb_a | input | 16 | Time base bus 0 |
| tb_b | input | 16 | Time base bus 1 |
| pin_in | input | 1 | Asynchronous measured pin |
| flag_irq | output | 1 | Capture-complete flag and interrupt |

## Verification
A pin change made before edge k is captured on edge k+2, and the captured value is the time base present just before that edge. The flag is visible just after that edge, and a read issued afterwards returns its data one clock later. The bench keeps a behavioural model that applies the same latencies and compares the flag and the read data at every falling clock edge. Directed checks record the time base counter at the moment the pin is driven and expect that value plus two counter steps. A flag-clear write is placed two cycles after a pin change so that it lands exactly on the capture edge.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int MODE_W   = 4;
  localparam int ADDR_W   = 2;
  localparam int BIT_POL  = 4;
  localparam int BIT_BSEL = 5;
  localparam int BIT_FLAG = 8;
  localparam int BIT_PIN  = 9;

  localparam logic [MODE_W-1:0] MODE_OFF = 4'd0;
  localparam logic [MODE_W-1:0] MODE_PW  = 4'd1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 2'd0,
    RA_DATA_A = 2'd1,
    RA_DATA_B = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              pol;
    logic              bsel;
  } ctrl_t;
endpackage

// File: rtl/pwcap_edge.sv
module pwcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic pol,
  output logic level,
  output logic lead_ev,
  output logic trail_ev
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level    = sync_q[STAGES-1];
  assign rise     = level & ~prev_q;
  assign fall     = ~level & prev_q;
  assign lead_ev  = pol ? fall : rise;
  assign trail_ev = pol ? rise : fall;
endmodule

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              new_pol,
  input  logic              new_bsel,
  input  logic              new_clr,
  output ctrl_t             ctrl_q,
  output logic              mode_chg,
  output logic              clr_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.mode <= new_mode;
      ctrl_q.pol  <= new_pol;
      ctrl_q.bsel <= new_bsel;
    end
  end

  assign mode_chg = ctrl_wr && (new_mode != ctrl_q.mode);
  assign clr_req  = ctrl_wr && new_clr;
endmodule

// File: rtl/pwcap_seq.sv
module pwcap_seq #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            mode_chg,
  input  logic            clr_req,
  input  logic            bsel,
  input  logic            lead_ev,
  input  logic            trail_ev,
  input  logic [TB_W-1:0] tb_a,
  input  logic [TB_W-1:0] tb_b,
  input  logic            b_load,
  input  logic [TB_W-1:0] b_load_val,
  output logic [TB_W-1:0] a_q,
  output logic [TB_W-1:0] b2_q,
  output logic            flag_q,
  output logic            wait_q
);
  logic [TB_W-1:0] b1_q;
  logic [TB_W-1:0] tb_sel;
  logic            cap_en, lead_cap, trail_cap;

  assign tb_sel    = bsel ? tb_b : tb_a;
  assign cap_en    = active && !mode_chg;
  assign lead_cap  = cap_en && lead_ev && !wait_q;
  assign trail_cap = cap_en && trail_ev && wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      b1_q <= '0;
      b2_q <= '0;
      a_q  <= '0;
    end else if (b_load) begin
      b1_q <= b_load_val;
      b2_q <= b_load_val;
    end else if (lead_cap) begin
      b1_q <= tb_sel;
    end else if (trail_cap) begin
      a_q  <= tb_sel;
      b2_q <= b1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_chg) begin
      wait_q <= 1'b0;
    end else if (lead_cap) begin
      wait_q <= 1'b1;
    end else if (trail_cap) begin
      wait_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cap_en) begin
      flag_q <= 1'b0;
    end else if (trail_cap) begin
      flag_q <= 1'b1;
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel
  import pwcap_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TB_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TB_W-1:0]   rd_data,
  input  logic [TB_W-1:0]   tb_a,
  input  logic [TB_W-1:0]   tb_b,
  input  logic              pin_in,
  output logic              flag_irq
);
  ctrl_t           ctrl_q;
  logic            mode_chg, clr_req, ctrl_wr, b_any_wr, b_load, active;
  logic            level, lead_ev, trail_ev;
  logic [TB_W-1:0] a_q, b2_q, ctrl_word;
  logic            flag_q, wait_q;

  assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
  assign b_any_wr = wr_en && (wr_addr == RA_DATA_B);
  assign active   = (ctrl_q.mode == MODE_PW);
  assign b_load   = b_any_wr && !active;

  pwcap_ctrl ctrl_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .new_mode(wr_data[MODE_W-1:0]), .new_pol(wr_data[BIT_POL]),
    .new_bsel(wr_data[BIT_BSEL]), .new_clr(wr_data[BIT_FLAG]),
    .ctrl_q(ctrl_q), .mode_chg(mode_chg), .clr_req(clr_req)
  );

  pwcap_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pol(ctrl_q.pol),
    .level(level), .lead_ev(lead_ev), .trail_ev(trail_ev)
  );

  pwcap_seq #(.TB_W(TB_W)) seq_i (
    .clk(clk), .rst(rst), .active(active), .mode_chg(mode_chg),
    .clr_req(clr_req), .bsel(ctrl_q.bsel), .lead_ev(lead_ev),
    .trail_ev(trail_ev), .tb_a(tb_a), .tb_b(tb_b), .b_load(b_load),
    .b_load_val(wr_data), .a_q(a_q), .b2_q(b2_q), .flag_q(flag_q),
    .wait_q(wait_q)
  );

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[MODE_W-1:0]     = ctrl_q.mode;
    ctrl_word[BIT_POL]        = ctrl_q.pol;
    ctrl_word[BIT_BSEL]       = ctrl_q.bsel;
    ctrl_word[BIT_FLAG]       = flag_q;
    ctrl_word[BIT_PIN]        = level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        RA_CTRL:   rd_data <= ctrl_word;
        RA_DATA_A: rd_data <= a_q;
        RA_DATA_B: rd_data <= b2_q;
        default:   rd_data <= '0;
      endcase
    end
  end

  assign flag_irq = flag_q;
endmodule

// File: rtl/pwcap_channel_chk.sv
module pwcap_channel_chk
  import pwcap_pkg::*;
#(
  parameter int TB_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic              mode_chg,
  input logic              b_wr,
  input logic [MODE_W-1:0] mode,
  input logic              flag,
  input logic              wait_trail,
  input logic [TB_W-1:0]   a_val,
  input logic [TB_W-1:0]   b_val
);
  AST_INACTIVE_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_PW) |-> !flag); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && mode == MODE_PW && !ctrl_wr) |=> flag); // R8

  AST_B_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(b_val) |-> (flag || $past(b_wr))); // R7

  AST_A_CHANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$stable(a_val) |-> flag); // R3

  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !wait_trail); // R11
endmodule

bind pwcap_channel pwcap_channel_chk #(.TB_W(TB_W)) chk_i (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .mode_chg(mode_chg),
  .b_wr(b_any_wr), .mode(ctrl_q.mode), .flag(flag_q),
  .wait_trail(wait_q), .a_val(a_q), .b_val(b2_q)
);

// File: tb/pwcap_channel_tb_top.sv
`timescale 1ns/1ps
module pwcap_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic [15:0] tb_a = 16'd0;
  logic [15:0] tb_b = 16'd100;
  logic        pin_in = 1'b0;
  logic        flag_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwcap_channel dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tb_a(tb_a), .tb_b(tb_b), .pin_in(pin_in), .flag_irq(flag_irq)
  );

  always @(posedge clk) begin
    tb_a <= tb_a + 16'd1;
    tb_b <= tb_b + 16'd7;
  end

  // behavioural reference model
  bit          hist[$];
  logic [3:0]  m_mode;
  logic        m_pol, m_bsel, m_flag, m_wait;
  logic [15:0] m_a, m_b1, m_b2, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_mode = 4'd0; m_pol = 0; m_bsel = 0; m_flag = 0; m_wait = 0;
      m_a = 0; m_b1 = 0; m_b2 = 0; m_rd = 0;
    end else begin
      bit lvl, prv, lead, trail, ctrl_w, mchg, en, tset;
      logic [15:0] tbv;
      lvl = hist[1]; prv = hist[2];
      lead  = m_pol ? (!lvl && prv) : (lvl && !prv);
      trail = m_pol ? (lvl && !prv) : (!lvl && prv);
      case (rd_addr)
        2'd0: m_rd = {6'd0, lvl, m_flag, 2'd0, m_bsel, m_pol, m_mode};
        2'd1: m_rd = m_a;
        2'd2: m_rd = m_b2;
        default: m_rd = 16'd0;
      endcase
      tbv = m_bsel ? tb_b : tb_a;
      ctrl_w = wr_en && wr_addr == 2'd0;
      mchg = ctrl_w && wr_data[3:0] != m_mode;
      en = (m_mode == 4'd1) && !mchg;
      tset = 0;
      if (m_mode != 4'd1 && wr_en && wr_addr == 2'd2) begin
        m_b1 = wr_data; m_b2 = wr_data;
      end else if (en && lead && !m_wait) begin
        m_b1 = tbv; m_wait = 1;
      end else if (en && trail && m_wait) begin
        m_a = tbv; m_b2 = m_b1; m_wait = 0; tset = 1;
      end
      if (!en) m_flag = 0;
      else if (tset) m_flag = 1;
      else if (ctrl_w && wr_data[8]) m_flag = 0;
      if (mchg) m_wait = 0;
      if (ctrl_w) begin
        m_mode = wr_data[3:0]; m_pol = wr_data[4]; m_bsel = wr_data[5];
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 model flag", {15'd0, flag_irq}, {15'd0, m_flag});
      chk("R12 model rd_data", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pin(input logic v, output logic [15:0] ta, output logic [15:0] tbb);
    pin_in = v; ta = tb_a; tbb = tb_b;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, t0, t1, b0, b1, u;
    logic [15:0] a_keep;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(2'd0, v); chk("R12 reset ctrl", v, 16'h0000);
    chk("R12 reset flag", {15'd0, flag_irq}, 16'd0);

    // disable mode: pin visible, no capture
    pin(1'b1, t0, u);
    rd(2'd0, v); chk("R1 pin level", v, 16'h0200);
    rd(2'd1, v); chk("R1 no capture A", v, 16'h0000);

    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R2 B preload", v, 16'h1234);

    // unsupported mode behaves as disable
    wr(2'd0, 16'h0005);
    wr(2'd2, 16'h5678);
    rd(2'd2, v); chk("R2 B preload unsupported", v, 16'h5678);
    pin(1'b0, t0, u); pin(1'b1, t0, u); pin(1'b0, t0, u); pin(1'b1, t0, u);
    rd(2'd1, v); chk("R1 unsupported no capture", v, 16'h0000);
    chk("R1 unsupported flag", {15'd0, flag_irq}, 16'd0);

    // pulse-width mode, rising leading edge, tb_a
    wr(2'd0, 16'h0001);
    pin(1'b0, t0, u);
    rd(2'd1, v); chk("R5 orphan trailing A", v, 16'h0000);
    chk("R5 orphan trailing flag", {15'd0, flag_irq}, 16'd0);
    wr(2'd2, 16'hAAAA);
    rd(2'd2, v); chk("R2 B write ignored in mode 1", v, 16'h5678);
    pin(1'b1, t0, u);
    rd(2'd2, v); chk("R6 B unchanged after lead", v, 16'h5678);
    chk("R6 flag after lead", {15'd0, flag_irq}, 16'd0);
    pin(1'b0, t1, u);
    chk("R7 flag after trail", {15'd0, flag_irq}, 16'd1);
    rd(2'd1, v); chk("R3 A trailing value", v, t1 + 16'd2);
    rd(2'd2, v); chk("R7 B leading value", v, t0 + 16'd2);

    // tb_b selected, second pulse while flag set
    wr(2'd0, 16'h0021);
    pin(1'b1, u, b0);
    pin(1'b0, u, b1);
    chk("R8 flag stays", {15'd0, flag_irq}, 16'd1);
    rd(2'd1, v); chk("R9 A from tb_b", v, b1 + 16'd14);
    rd(2'd2, v); chk("R8 B updated", v, b0 + 16'd14);

    // clear flag
    wr(2'd0, 16'h0121);
    @(negedge clk);
    chk("R10 flag cleared", {15'd0, flag_irq}, 16'd0);
    rd(2'd0, v); chk("R12 ctrl readback", v, 16'h0021);

    // clear coinciding with trailing capture
    pin(1'b1, u, b0);
    pin_in = 1'b0; b1 = tb_b;
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0121);
    repeat (3) @(negedge clk);
    chk("R10 capture beats clear", {15'd0, flag_irq}, 16'd1);
    a_keep = b1 + 16'd14;
    rd(2'd1, v); chk("R10 A on collision", v, a_keep);

    // falling leading edge
    wr(2'd0, 16'h0011);
    pin(1'b1, u, u);
    rd(2'd1, v); chk("R4 rising is trailing, ignored", v, a_keep);
    pin(1'b0, t0, u);
    pin(1'b1, t1, u);
    rd(2'd1, v); chk("R4 A negative pulse", v, t1 + 16'd2);
    rd(2'd2, v); chk("R4 B negative pulse", v, t0 + 16'd2);
    a_keep = t1 + 16'd2;

    // re-arm on mode change
    wr(2'd0, 16'h0111);
    pin(1'b0, u, u);
    wr(2'd0, 16'h0010);
    wr(2'd0, 16'h0011);
    pin(1'b1, u, u);
    chk("R11 no flag after rearm", {15'd0, flag_irq}, 16'd0);
    rd(2'd1, v); chk("R11 A unchanged after rearm", v, a_keep);

    // entering disable clears a set flag
    pin(1'b0, u, u);
    pin(1'b1, u, u);
    chk("R7 flag before disable", {15'd0, flag_irq}, 16'd1);
    wr(2'd0, 16'h0010);
    chk("R1 disable clears flag", {15'd0, flag_irq}, 16'd0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule